// File: doc/BRIEF.md
# Six-Channel Packed Serial Audio Receiver

This block deserialises one audio data line that carries six channels per frame: three left samples followed by three right samples. An external bit clock, a framing clock and the data line are sampled by a faster system clock. Each bit-clock rising edge becomes a one-cycle event in the system clock domain. The framing clock marks where each frame starts. A bit counter locates the slot, and a shift register assembles each word. When a frame completes, all six words are presented together with a one-cycle valid pulse.

Two frame layouts are supported, chosen by a static input. The short layout is 128 bit clocks with 20-bit slots and a 4-bit gap after each half. The long layout is 256 bit clocks with 32-bit slots, a blank slot after each half, and a one-bit delay before each word. The word length is 16, 20 or 24 bits, set by a second static input. A framing edge at an unexpected bit count raises a sync-error pulse. The receiver then discards data until the next frame start.

Top module: `packed_tdm_rx`

## Requirements
- R1: While reset is asserted and until the first completed frame, all six word outputs are zero and frame_valid and sync_err are low.
- R2: With mode_256 = 0 the frame is 128 bits, counted from 0 at the frame start. Channel c (left0..left2 = 0..2, right0..right2 = 3..5) begins at bit 64*(c/3) + 20*(c%3). Bits 60..63 and 124..127, and slot bits beyond the word length, are ignored.
- R3: With mode_256 = 1 the frame is 256 bits made of 32-bit slots. Left channels use slots 0..2 and right channels use slots 4..6. Each word begins at bit 1 of its slot. Bit 0 of each slot, the unused slot tail, and slots 3 and 7 are ignored.
- R4: Words are sent MSB first. Each bit is sampled at the bit-clock rising edge, after a two-stage synchronizer. The system clock runs at least 4 times faster than the bit clock.
- R5: A frame starts at the bit where the framing clock has changed to the left-half level. That level is high with mode_256 = 0 and low with mode_256 = 1. The first framing transition seen after reset only primes the detector when it goes to the right-half level.
- R6: word_len encodes 00 = 16 bits, 01 = 20 bits, 10 or 11 = 24 bits. With mode_256 = 0, a 24-bit setting is received as 20 bits.
- R7: Each word is placed left-aligned in its 24-bit output, and the unused low bits are zero.
- R8: frame_valid is high for exactly one system clock per good frame, shortly after the last right2 bit is captured. All six outputs change only in that cycle and hold their values until the next one.
- R9: A framing edge into the left level at a bit count other than the frame length, or into the right level at a count other than half the frame length, gives a one-cycle sync_err pulse. After a misplaced right edge, the rest of that frame gives no frame_valid. A misplaced left edge starts a new frame, which is then accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_256 | input | 1 | Static layout select: 0 = 128-bit frame, 1 = 256-bit frame |
| word_len | input | 2 | Static word length code (see R6) |
| bclk | input | 1 | External bit clock |
| fclk | input | 1 | External framing clock |
| sdata | input | 1 | Serial data, launched on the bit-clock falling edge |
| left0 | output | 24 | Left channel 0 word, left-aligned |
| left1 | output | 24 | Left channel 1 word, left-aligned |
| left2 | output | 24 | Left channel 2 word, left-aligned |
| right0 | output | 24 | Right channel 0 word, left-aligned |
| right1 | output | 24 | Right channel 1 word, left-aligned |
| right2 | output | 24 | Right channel 2 word, left-aligned |
| frame_valid | output | 1 | One-cycle pulse when a new set of six words is presented |
| sync_err | output | 1 | One-cycle pulse on a misplaced framing edge |

## Verification
The assertions check several properties on every cycle:
- bit events are never on adjacent cycles;
- frame_valid lasts a single cycle and always follows a captured bit;
- the outputs stay stable between valid pulses;
- sync_err only follows a framing transition;
- with 16-bit words, the low byte is always zero.

Slot placement, MSB order, the ignored gap and delay bits, the framing polarity of each layout, the 24-to-20 clamp, and discarding and realigning after a sync error can only be shown by the bench. The bench does this by sending complete frames with known samples and comparing the presented words.

// File: rtl/ptdm_pkg.sv
package ptdm_pkg;

  localparam int SAMPLE_W = 24;
  localparam int NUM_CH   = 6;

  typedef struct packed {
    logic       hit;
    logic [2:0] chan;
    logic       first;
    logic       last;
  } slot_pos_t;

  // Effective word length for a layout and a length code
  function automatic int eff_len(logic m256, logic [1:0] code);
    int n;
    case (code)
      2'b00:   n = 16;
      2'b01:   n = 20;
      default: n = 24;
    endcase
    if (!m256 && n > 20) n = 20;
    return n;
  endfunction

  function automatic int frame_len(logic m256);
    return m256 ? 256 : 128;
  endfunction

  // Map a bit position within the frame onto channel / bit-of-word
  function automatic slot_pos_t decode_pos(logic m256, int wlen, int pos);
    slot_pos_t r;
    int slot, b, half, off, j;
    r = '0;
    if (m256) begin
      if (pos < 256) begin
        slot = pos / 32;
        b    = (pos % 32) - 1;
        if (slot != 3 && slot != 7 && b >= 0 && b < wlen) begin
          r.hit   = 1'b1;
          r.chan  = 3'((slot < 3) ? slot : slot - 1);
          r.first = (b == 0);
          r.last  = (b == wlen - 1);
        end
      end
    end else begin
      if (pos < 128) begin
        half = pos / 64;
        off  = pos % 64;
        j    = off / 20;
        b    = off % 20;
        if (off < 60 && b < wlen) begin
          r.hit   = 1'b1;
          r.chan  = 3'(half * 3 + j);
          r.first = (b == 0);
          r.last  = (b == wlen - 1);
        end
      end
    end
    return r;
  endfunction

  function automatic logic [SAMPLE_W-1:0] left_align(logic [SAMPLE_W-1:0] w, int wlen);
    return w << (SAMPLE_W - wlen);
  endfunction

endpackage

// File: rtl/ptdm_sync.sv
module ptdm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fclk,
  input  logic sdata,
  output logic bit_tick,
  output logic fclk_s,
  output logic sdata_s
);

  localparam int NSIG = 3;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            bclk_q;

  assign raw = {sdata, fclk, bclk};

  for (genvar g = 0; g < NSIG; g++) begin : g_chain
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= synced[0];
  end

  assign bit_tick = synced[0] & ~bclk_q;
  assign fclk_s   = synced[1];
  assign sdata_s  = synced[2];

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

endmodule

// File: rtl/ptdm_framer.sv
module ptdm_framer import ptdm_pkg::*; #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_256,
  input  logic             bit_tick,
  input  logic             fclk_s,
  output logic [CNT_W-1:0] pos,
  output logic             fclk_edge,
  output logic             hunting,
  output logic             sync_err
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             primed;
  logic             fclk_prev;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] exp_pos;
  logic             into_left;
  logic             frame_start;
  logic             misplaced;

  assign fclk_edge   = bit_tick & primed & (fclk_s != fclk_prev);
  assign into_left   = (fclk_s == ~mode_256);
  assign frame_start = fclk_edge & into_left;
  assign nxt         = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
  assign pos         = frame_start ? '0 : nxt;
  assign exp_pos     = into_left ? CNT_W'(frame_len(mode_256))
                                 : CNT_W'(frame_len(mode_256) / 2);
  assign misplaced   = fclk_edge & ~hunting & (nxt != exp_pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed    <= 1'b0;
      fclk_prev <= 1'b0;
      cnt       <= CNT_MAX;
      hunting   <= 1'b1;
      sync_err  <= 1'b0;
    end else begin
      sync_err <= misplaced;
      if (bit_tick) begin
        primed    <= 1'b1;
        fclk_prev <= fclk_s;
        cnt       <= pos;
        if (frame_start)    hunting <= 1'b0;
        else if (misplaced) hunting <= 1'b1;
      end
    end
  end

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> !sync_err);

endmodule

// File: rtl/ptdm_capture.sv
module ptdm_capture import ptdm_pkg::*; #(
  parameter int CNT_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_256,
  input  logic [1:0]          word_len,
  input  logic                bit_tick,
  input  logic                sdata_s,
  input  logic                hunting,
  input  logic [CNT_W-1:0]    pos,
  output logic [SAMPLE_W-1:0] word_q [NUM_CH],
  output logic                frame_valid
);

  int                  wlen;
  slot_pos_t           dec;
  logic [SAMPLE_W-1:0] shift_q;
  logic [SAMPLE_W-1:0] word_now;
  logic [SAMPLE_W-1:0] aligned;
  logic [SAMPLE_W-1:0] hold [NUM_CH-1];

  always_comb wlen = eff_len(mode_256, word_len);
  always_comb dec  = decode_pos(mode_256, wlen, int'(pos));

  assign word_now = {shift_q[SAMPLE_W-2:0], sdata_s};
  assign aligned  = left_align(word_now, wlen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q     <= '0;
      hold        <= '{default: '0};
      word_q      <= '{default: '0};
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (bit_tick && dec.hit) begin
        shift_q <= dec.first ? {{(SAMPLE_W-1){1'b0}}, sdata_s} : word_now;
        if (dec.last) begin
          if (dec.chan != 3'(NUM_CH - 1)) begin
            hold[dec.chan] <= aligned;
          end else if (!hunting) begin
            for (int k = 0; k < NUM_CH - 1; k++) word_q[k] <= hold[k];
            word_q[NUM_CH-1] <= aligned;
            frame_valid      <= 1'b1;
          end
        end
      end
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

endmodule

// File: rtl/packed_tdm_rx.sv
module packed_tdm_rx import ptdm_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_256,
  input  logic [1:0]          word_len,
  input  logic                bclk,
  input  logic                fclk,
  input  logic                sdata,
  output logic [SAMPLE_W-1:0] left0,
  output logic [SAMPLE_W-1:0] left1,
  output logic [SAMPLE_W-1:0] left2,
  output logic [SAMPLE_W-1:0] right0,
  output logic [SAMPLE_W-1:0] right1,
  output logic [SAMPLE_W-1:0] right2,
  output logic                frame_valid,
  output logic                sync_err
);

  logic                bit_tick;
  logic                fclk_s;
  logic                sdata_s;
  logic [CNT_W-1:0]    pos;
  logic                fclk_edge;
  logic                hunting;
  logic [SAMPLE_W-1:0] words [NUM_CH];
  int                  wlen;

  always_comb wlen = eff_len(mode_256, word_len);

  ptdm_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk     (bclk),
    .fclk     (fclk),
    .sdata    (sdata),
    .bit_tick (bit_tick),
    .fclk_s   (fclk_s),
    .sdata_s  (sdata_s)
  );

  ptdm_framer #(.CNT_W(CNT_W)) i_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_256  (mode_256),
    .bit_tick  (bit_tick),
    .fclk_s    (fclk_s),
    .pos       (pos),
    .fclk_edge (fclk_edge),
    .hunting   (hunting),
    .sync_err  (sync_err)
  );

  ptdm_capture #(.CNT_W(CNT_W)) i_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_256    (mode_256),
    .word_len    (word_len),
    .bit_tick    (bit_tick),
    .sdata_s     (sdata_s),
    .hunting     (hunting),
    .pos         (pos),
    .word_q      (words),
    .frame_valid (frame_valid)
  );

  assign left0  = words[0];
  assign left1  = words[1];
  assign left2  = words[2];
  assign right0 = words[3];
  assign right1 = words[4];
  assign right2 = words[5];

  // R9
  err_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> $past(fclk_edge));

  // R8
  valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(bit_tick));

  // R8
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> $stable({left0, left1, left2, right0, right1, right2}));

  // R7
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && wlen == 16) |-> (left0[7:0] == 8'h0 && right2[7:0] == 8'h0));

endmodule

// File: tb/test_packed_tdm_rx.sv
module test_packed_tdm_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_256 = 1'b0;
  logic [1:0]  word_len = 2'b00;
  logic        bclk = 1'b0;
  logic        fclk = 1'b0;
  logic        sdata = 1'b0;
  logic [23:0] left0, left1, left2, right0, right1, right2;
  logic        frame_valid, sync_err;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  int ecount = 0;
  bit done = 1'b0;

  logic [23:0] samp [6];
  logic        fb [256];

  // {mode[11], word_len[10:9], noise[8], seed[7:0]}
  localparam logic [11:0] VEC [7] = '{
    12'h011, 12'h35A, 12'h5C3, 12'h977, 12'hA2E, 12'hDF0, 12'hE39
  };

  always #4 clk = ~clk;

  packed_tdm_rx i_packed_tdm_rx (
    .clk(clk), .rst_n(rst_n), .mode_256(mode_256), .word_len(word_len),
    .bclk(bclk), .fclk(fclk), .sdata(sdata),
    .left0(left0), .left1(left1), .left2(left2),
    .right0(right0), .right1(right1), .right2(right2),
    .frame_valid(frame_valid), .sync_err(sync_err)
  );

  always @(negedge clk) begin
    if (rst_n && frame_valid) vcount++;
    if (rst_n && sync_err)    ecount++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bits_for(logic m, logic [1:0] code);
    int n;
    n = (code == 2'b00) ? 16 : ((code == 2'b01) ? 20 : 24);
    return (!m && n == 24) ? 20 : n;
  endfunction

  function automatic logic [23:0] mk(int seed, int fr, int ch);
    logic [31:0] x;
    x = seed * 32'h01000193 + fr * 32'h9E3779B1 + ch * 32'h85EBCA6B;
    x = x ^ (x >> 13);
    return x[23:0];
  endfunction

  function automatic logic [23:0] expect_word(logic [23:0] s, int n);
    logic [23:0] m;
    m = ~(24'hFFFFFF >> n);
    return s & m;
  endfunction

  function automatic logic [23:0] out_of(int ch);
    case (ch)
      0: return left0;  1: return left1;  2: return left2;
      3: return right0; 4: return right1; default: return right2;
    endcase
  endfunction

  task automatic send_bit(input logic b, input logic f);
    bclk = 1'b0; sdata = b; fclk = f;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic build(input logic m, input logic [1:0] code, input logic noise, input int seed, input int fr);
    int n, base;
    n = bits_for(m, code);
    for (int p = 0; p < 256; p++) fb[p] = noise;
    for (int c = 0; c < 6; c++) begin
      samp[c] = mk(seed, fr, c);
      if (m) base = ((c / 3) * 4 + (c % 3)) * 32 + 1;
      else   base = (c / 3) * 64 + (c % 3) * 20;
      for (int b = 0; b < n; b++) fb[base + b] = samp[c][23 - b];
    end
  endtask

  task automatic send_frame(input logic m, input int len, input int half_pos);
    logic lft;
    lft = ~m;
    for (int p = 0; p < len; p++) send_bit(fb[p], (p < half_pos) ? lft : ~lft);
  endtask

  task automatic do_reset(input logic m, input logic [1:0] code);
    @(negedge clk);
    rst_n = 1'b0; mode_256 = m; word_len = code; bclk = 1'b0; sdata = 1'b0; fclk = m;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) send_bit(1'b0, m);  // right-half level primes
  endtask

  task automatic check_words(input string tag, input int n);
    for (int c = 0; c < 6; c++) check(tag, out_of(c), expect_word(samp[c], n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v0, e0;
    logic [23:0] keep [6];

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 left0 in reset", left0, 0);
    check("R1 right2 in reset", right2, 0);
    check("R1 frame_valid in reset", frame_valid, 0);
    check("R1 sync_err in reset", sync_err, 0);

    // Table-driven: layouts, word lengths, noise in ignored bits
    for (int t = 0; t < 7; t++) begin
      logic m;
      logic [1:0] code;
      logic noise;
      int seed;
      m = VEC[t][11]; code = VEC[t][10:9]; noise = VEC[t][8]; seed = int'(VEC[t][7:0]);
      do_reset(m, code);
      if (t == 0) begin
        check("R1 outputs zero before first frame", left1, 0);
        check("R1 no valid before first frame", vcount, 0);
      end
      for (int fr = 0; fr < 2; fr++) begin
        v0 = vcount; e0 = ecount;
        build(m, code, noise, seed, fr);
        send_frame(m, m ? 256 : 128, m ? 128 : 64);
        // R2 / R3 slot layout, R4 MSB order, R5 polarity, R6 length, R7 alignment
        check_words(m ? "R3 R4 R5 R6 R7 word" : "R2 R4 R5 R6 R7 word", bits_for(m, code));
        check("R8 one valid pulse per frame", vcount - v0, 1);
        check("R9 no error on good frame", ecount - e0, 0);
      end
    end

    // R9: misplaced right edge in 256 layout, frame discarded, then realign
    do_reset(1'b1, 2'b10);
    build(1'b1, 2'b10, 1'b0, 99, 0);
    send_frame(1'b1, 256, 128);
    for (int c = 0; c < 6; c++) keep[c] = samp[c];
    v0 = vcount; e0 = ecount;
    build(1'b1, 2'b10, 1'b0, 99, 1);
    send_frame(1'b1, 256, 120);
    check("R9 misplaced right edge flagged", ecount - e0, 1);
    check("R9 bad frame gives no valid", vcount - v0, 0);
    for (int c = 0; c < 6; c++) check("R8 R9 outputs held after bad frame", out_of(c), keep[c]);
    v0 = vcount; e0 = ecount;
    build(1'b1, 2'b10, 1'b0, 99, 2);
    send_frame(1'b1, 256, 128);
    check("R9 realigned frame valid", vcount - v0, 1);
    check("R9 no error after realign", ecount - e0, 0);
    check_words("R9 realigned data", 24);

    // R9: early frame start in 128 layout
    do_reset(1'b0, 2'b01);
    build(1'b0, 2'b01, 1'b1, 45, 0);
    send_frame(1'b0, 128, 64);
    v0 = vcount; e0 = ecount;
    build(1'b0, 2'b01, 1'b1, 45, 1);
    send_frame(1'b0, 100, 64);
    check("R9 truncated frame gives no valid", vcount - v0, 0);
    build(1'b0, 2'b01, 1'b1, 45, 2);
    send_frame(1'b0, 128, 64);
    check("R9 early left edge flagged", ecount - e0, 1);
    check("R9 frame after early start valid", vcount - v0, 1);
    check_words("R9 data after early start", 20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule